// File: doc/BRIEF.md
# Edge-Aligned PWM Timer with Buffered Duty Register

This block is a 16-bit timer that drives one edge-aligned PWM output. An up-counter runs from zero to a programmable modulus and then wraps, which sets an overflow flag and starts a new PWM period. A single channel compares the counter with an active compare value. The output is asserted from count zero until the match, and deasserted for the rest of the period. Each match sets a channel flag.

A CPU programs the block through an 8-bit register port. The compare value is written as a high byte and then a low byte. While the counter runs, the completed value waits in a buffer. It moves into the active register only at the period boundary, so the duty cycle never changes in the middle of a period. Whether a write is accepted depends on neither the channel interrupt enable nor the counter's position relative to the old compare value. Each flag is cleared by a read of the status register while the flag is set, followed by a write of zero to that flag bit. Each flag has its own interrupt enable.

Top module: `epwm_timer`

## Requirements
- R1: While running, the counter steps from 0 up to the top value and then returns to 0. The top value is the modulus, or 0xFFFF when the modulus is 0. While stopped, the counter holds its value.
- R2: The overflow flag (status bit 0) sets on the cycle the counter wraps from the top value to 0.
- R3: A write to address 4 stores the high compare byte in a holding latch. A write to address 5 completes the value. While running, the completed value becomes pending and loads into the active compare register when the counter steps from top minus 1 to top. This happens whatever the channel interrupt enable or the counter position.
- R4: With a modulus of 0, a pending compare value loads when the counter steps from 0xFFFE to 0xFFFF, and not before.
- R5: While the counter is stopped, a completed compare write goes straight into the active compare register.
- R6: A pending value that is overwritten before it loads is replaced by the newer value.
- R7: With the low-true bit clear, the output is high when the counter is below the active compare value and low otherwise. A compare value of 0 gives a constant low, and a value above the modulus gives a constant high. Modulus 40000 with compare 20000 gives 20000 high cycles in each 40001-cycle period. Setting the low-true bit inverts the output.
- R8: The channel flag (status bit 1) sets on every cycle in which the running counter equals the active compare value.
- R9: A flag clears only if the status register was read while that flag was set and the next status write carries 0 in that bit. Writing 1, or writing 0 without an arming read, leaves the flag set. Any status write disarms both flags. A flag event in the same cycle as a clear wins.
- R10: The interrupt request is high exactly when the overflow flag is set with its enable, or the channel flag is set with its enable.
- R11: Register map. Address 0 is control: bit 0 run, bit 1 overflow interrupt enable, bit 2 channel interrupt enable, bit 3 low-true. Address 1 is status. Addresses 2/3 are the modulus high/low. Addresses 4/5 are the compare high/low; a read returns the active value. Addresses 6/7 read the counter high/low. Reset clears all state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read (arms flag clearing) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| pwmOut | output | 1 | PWM output level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a compare update near full duty. The counter sits below the old compare value, the channel interrupt is enabled, and the new value has to survive until the period boundary. The stimulus enables the channel interrupt, then polls the counter's low byte until the count falls below the old compare value, and writes the two bytes at that moment. A behavioural model then predicts the exact cycle of the load. The free-running fallback needs a full 65536-count period. The stimulus also checks that the value has not loaded at the boundary the previous, smaller modulus would have given.

// File: rtl/epwm_pkg.sv
package epwm_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;
  localparam int NBYTES = CNT_W / BYTE_W;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_MODH = 3'd2;
  localparam logic [ADDR_W-1:0] A_MODL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMPH = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMPL = 3'd5;
  localparam logic [ADDR_W-1:0] A_CNTH = 3'd6;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd7;

  typedef struct packed {
    logic [NBYTES-1:0] modWr;
    logic              cmpHiWr;
    logic              cmpLoWr;
    logic [BYTE_W-1:0] data;
  } busStrobe_t;
endpackage

// File: rtl/epwm_ctrl.sv
module epwm_ctrl
  import epwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [BYTE_W-1:0]    busWdata,
  output logic [BYTE_W-1:0]    busRdata,
  input  logic                 wrapEvt,
  input  logic                 matchEvt,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [CNT_W-1:0]     modVal,
  input  logic [CNT_W-1:0]     actCmp,
  output busStrobe_t           strb,
  output logic                 run,
  output logic                 lowTrue,
  output logic                 ovfIntEn,
  output logic                 chIntEn,
  output logic                 ovfFlag,
  output logic                 chFlag,
  output logic                 irq
);
  logic [3:0] ctrlReg;
  logic [1:0] armed;
  logic statWr, statRd, ovfClr, chClr;

  assign run      = ctrlReg[0];
  assign ovfIntEn = ctrlReg[1];
  assign chIntEn  = ctrlReg[2];
  assign lowTrue  = ctrlReg[3];

  assign statWr = busWr && (busAddr == A_STAT);
  assign statRd = busRd && (busAddr == A_STAT);
  assign ovfClr = statWr && armed[0] && !busWdata[0];
  assign chClr  = statWr && armed[1] && !busWdata[1];

  always_comb begin
    strb.modWr[NBYTES-1] = busWr && (busAddr == A_MODH);
    strb.modWr[0]        = busWr && (busAddr == A_MODL);
    strb.cmpHiWr         = busWr && (busAddr == A_CMPH);
    strb.cmpLoWr         = busWr && (busAddr == A_CMPL);
    strb.data            = busWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      ovfFlag <= 1'b0;
      chFlag  <= 1'b0;
      armed   <= '0;
    end else begin
      if (busWr && (busAddr == A_CTRL)) ctrlReg <= busWdata[3:0];
      ovfFlag <= wrapEvt  | (ovfFlag & ~ovfClr);
      chFlag  <= matchEvt | (chFlag & ~chClr);
      if (statWr)      armed <= '0;
      else if (statRd) armed <= armed | {chFlag, ovfFlag};
    end
  end

  assign irq = (ovfFlag & ovfIntEn) | (chFlag & chIntEn);

  always_comb begin
    unique case (busAddr)
      A_CTRL:  busRdata = {4'b0, ctrlReg};
      A_STAT:  busRdata = {6'b0, chFlag, ovfFlag};
      A_MODH:  busRdata = modVal[CNT_W-1 -: BYTE_W];
      A_MODL:  busRdata = modVal[BYTE_W-1:0];
      A_CMPH:  busRdata = actCmp[CNT_W-1 -: BYTE_W];
      A_CMPL:  busRdata = actCmp[BYTE_W-1:0];
      A_CNTH:  busRdata = cnt[CNT_W-1 -: BYTE_W];
      default: busRdata = cnt[BYTE_W-1:0];
    endcase
  end
endmodule

// File: rtl/epwm_datapath.sv
module epwm_datapath
  import epwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       strb,
  input  logic             run,
  input  logic             lowTrue,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] modVal,
  output logic [CNT_W-1:0] actCmp,
  output logic [CNT_W-1:0] cmpBuf,
  output logic             cmpPend,
  output logic             wrapEvt,
  output logic             matchEvt,
  output logic             pwmOut
);
  logic [BYTE_W-1:0] cmpHold;
  logic [CNT_W-1:0]  topVal, newCmp;
  logic              loadEvt;

  assign topVal   = (modVal == '0) ? '1 : modVal;
  assign wrapEvt  = run && (cnt == topVal);
  assign matchEvt = run && (cnt == actCmp);
  assign loadEvt  = run && cmpPend && (cnt == topVal - CNT_W'(1));
  assign newCmp   = {cmpHold, strb.data};

  always_ff @(posedge clk) begin
    if (!rstN)        cnt <= '0;
    else if (wrapEvt) cnt <= '0;
    else if (run)     cnt <= cnt + CNT_W'(1);
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_modLane
    always_ff @(posedge clk) begin
      if (!rstN)                modVal[b*BYTE_W +: BYTE_W] <= '0;
      else if (strb.modWr[b])   modVal[b*BYTE_W +: BYTE_W] <= strb.data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpHold <= '0;
      cmpBuf  <= '0;
      cmpPend <= 1'b0;
      actCmp  <= '0;
    end else begin
      if (strb.cmpHiWr) cmpHold <= strb.data;
      if (loadEvt) actCmp <= cmpBuf;
      if (strb.cmpLoWr && run) begin
        cmpBuf  <= newCmp;
        cmpPend <= 1'b1;
      end else if (strb.cmpLoWr) begin
        actCmp  <= newCmp;
        cmpPend <= 1'b0;
      end else if (loadEvt) begin
        cmpPend <= 1'b0;
      end
    end
  end

  assign pwmOut = (cnt < actCmp) ^ lowTrue;
endmodule

// File: rtl/epwm_timer.sv
module epwm_timer
  import epwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              pwmOut,
  output logic              irq
);
  busStrobe_t       strb;
  logic             run, lowTrue, ovfIntEn, chIntEn, ovfFlag, chFlag;
  logic             wrapEvt, matchEvt, cmpPend;
  logic [CNT_W-1:0] cnt, modVal, actCmp, cmpBuf;

  epwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .wrapEvt(wrapEvt),
    .matchEvt(matchEvt), .cnt(cnt), .modVal(modVal), .actCmp(actCmp),
    .strb(strb), .run(run), .lowTrue(lowTrue), .ovfIntEn(ovfIntEn),
    .chIntEn(chIntEn), .ovfFlag(ovfFlag), .chFlag(chFlag), .irq(irq)
  );

  epwm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .run(run), .lowTrue(lowTrue),
    .cnt(cnt), .modVal(modVal), .actCmp(actCmp), .cmpBuf(cmpBuf),
    .cmpPend(cmpPend), .wrapEvt(wrapEvt), .matchEvt(matchEvt), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/epwm_timer_chk.sv
module epwm_timer_chk
  import epwm_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       busAddr,
  input logic             busWr,
  input logic [7:0]       busWdata,
  input logic             run,
  input logic             lowTrue,
  input logic             ovfIntEn,
  input logic             chIntEn,
  input logic             ovfFlag,
  input logic             chFlag,
  input logic             irq,
  input logic             pwmOut,
  input logic             cmpPend,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] modVal,
  input logic [CNT_W-1:0] actCmp,
  input logic [CNT_W-1:0] cmpBuf
);
  logic [CNT_W-1:0] chkTop;
  assign chkTop = (modVal == '0) ? '1 : modVal;

  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && cnt == chkTop) |=> (cnt == '0));

  // R1
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> $stable(cnt));

  // R3
  buffer_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && cmpPend && cnt == chkTop - CNT_W'(1) && !(busWr && busAddr == A_CMPL))
      |=> (actCmp == $past(cmpBuf)));

  // R5
  direct_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!run && busWr && busAddr == A_CMPL) |=> (actCmp[7:0] == $past(busWdata)));

  // R7
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actCmp == '0) |-> (pwmOut == lowTrue));

  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag) |-> $past(busWr && busAddr == A_STAT && !busWdata[0]));

  // R9
  ch_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chFlag) |-> $past(busWr && busAddr == A_STAT && !busWdata[1]));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(ovfFlag && ovfIntEn) && !(chFlag && chIntEn)) |-> !irq);
endmodule

bind epwm_timer epwm_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
  .run(run), .lowTrue(lowTrue), .ovfIntEn(ovfIntEn), .chIntEn(chIntEn),
  .ovfFlag(ovfFlag), .chFlag(chFlag), .irq(irq), .pwmOut(pwmOut),
  .cmpPend(cmpPend), .cnt(cnt), .modVal(modVal), .actCmp(actCmp), .cmpBuf(cmpBuf)
);

// File: tb/sim_epwm_timer.sv
module sim_epwm_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       pwmOut, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  epwm_timer u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut), .irq(irq)
  );

  // behavioural reference
  int mCnt, mMod, mAct, mBuf, mHold;
  bit mPend, mOvf, mCh;
  bit [1:0] mArm;
  bit [3:0] mCtl;

  function automatic int topOf(int m);
    return (m == 0) ? 65535 : m;
  endfunction

  always @(posedge clk) begin
    int top, nCnt, nAct, nBuf, nMod, nHold, val;
    bit runB, wrapE, matchE, loadE, clrO, clrC, nPend;
    bit [3:0] nCtl;
    bit [1:0] nArm;
    if (!rstN) begin
      mCnt = 0; mMod = 0; mAct = 0; mBuf = 0; mHold = 0;
      mPend = 0; mOvf = 0; mCh = 0; mArm = 0; mCtl = 0;
    end else begin
      top = topOf(mMod);
      runB = mCtl[0];
      wrapE = runB && mCnt == top;
      matchE = runB && mCnt == mAct;
      loadE = runB && mPend && mCnt == top - 1;
      nCnt = runB ? (wrapE ? 0 : mCnt + 1) : mCnt;
      nAct = mAct; nBuf = mBuf; nPend = mPend; nMod = mMod; nHold = mHold; nCtl = mCtl;
      nArm = mArm; clrO = 0; clrC = 0;
      if (loadE) begin nAct = mBuf; nPend = 0; end
      if (busWr) begin
        case (busAddr)
          3'd0: nCtl = busWdata[3:0];
          3'd1: begin
            clrO = mArm[0] && !busWdata[0];
            clrC = mArm[1] && !busWdata[1];
            nArm = 0;
          end
          3'd2: nMod = (int'(busWdata) << 8) | (mMod & 255);
          3'd3: nMod = (mMod & 65280) | int'(busWdata);
          3'd4: nHold = int'(busWdata);
          3'd5: begin
            val = mHold * 256 + int'(busWdata);
            if (runB) begin nBuf = val; nPend = 1; end
            else begin nAct = val; nPend = 0; end
          end
          default: ;
        endcase
      end else if (busRd && busAddr == 3'd1) begin
        nArm = mArm | {mCh, mOvf};
      end
      mOvf = wrapE | (mOvf & !clrO);
      mCh  = matchE | (mCh & !clrC);
      mCnt = nCnt; mAct = nAct; mBuf = nBuf; mPend = nPend; mMod = nMod;
      mHold = nHold; mCtl = nCtl; mArm = nArm;
    end
  end

  function automatic int expRead(logic [2:0] a);
    case (a)
      3'd0: return int'(mCtl);
      3'd1: return (int'(mCh) << 1) | int'(mOvf);
      3'd2: return (mMod >> 8) & 255;
      3'd3: return mMod & 255;
      3'd4: return (mAct >> 8) & 255;
      3'd5: return mAct & 255;
      3'd6: return (mCnt >> 8) & 255;
      default: return mCnt & 255;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R7 pwm level", int'(pwmOut), int'((mCnt < mAct) ^ mCtl[3]));
      check("R10 irq", int'(irq), int'((mOvf && mCtl[1]) || (mCh && mCtl[2])));
      case (busAddr)
        3'd1:       check("R9 status read", int'(busRdata), expRead(busAddr));
        3'd4, 3'd5: check("R3 compare read", int'(busRdata), expRead(busAddr));
        3'd6, 3'd7: check("R1 counter read", int'(busRdata), expRead(busAddr));
        default:    check("R11 register read", int'(busRdata), expRead(busAddr));
      endcase
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int d);
    @(posedge clk); #1;
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    d = int'(busRdata);
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int v, hi;
    idle(3);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    check("R11 reset pwm", int'(pwmOut), 0);
    check("R11 reset irq", int'(irq), 0);
    rd(3'd7, v); check("R11 reset count", v, 0);

    // stopped compare write (R5)
    wr(3'd2, 8'd0); wr(3'd3, 8'd100);
    wr(3'd4, 8'd0); wr(3'd5, 8'd30);
    rd(3'd5, v); check("R5 direct load", v, 30);

    // run with both interrupts, flags (R2, R8)
    wr(3'd0, 8'h07);
    idle(250);
    wr(3'd0, 8'h06);
    rd(3'd1, v); check("R2 R8 flags set", v, 3);
    wr(3'd1, 8'h03);
    wr(3'd1, 8'h00);
    rd(3'd1, v); check("R9 no clear without arming read", v, 3);
    wr(3'd1, 8'h02);
    rd(3'd1, v); check("R9 partial clear", v, 2);
    @(negedge clk); check("R10 irq from channel", int'(irq), 1);
    wr(3'd0, 8'h02);
    @(negedge clk); check("R10 irq masked", int'(irq), 0);
    rd(3'd1, v); wr(3'd1, 8'h00);
    rd(3'd1, v); check("R9 cleared", v, 0);

    // near-full-duty update while below compare, channel irq on (R3)
    wr(3'd0, 8'h05);
    v = 255;
    while (v >= 20) rd(3'd7, v);
    wr(3'd4, 8'd0); wr(3'd5, 8'd95);
    rd(3'd5, v); check("R3 not loaded early", v, 30);
    idle(110);
    rd(3'd5, v); check("R3 loaded at boundary", v, 95);

    // back-to-back pending writes (R6)
    wr(3'd4, 8'd0); wr(3'd5, 8'd50);
    wr(3'd4, 8'd0); wr(3'd5, 8'd70);
    idle(220);
    rd(3'd5, v); check("R6 newest value wins", v, 70);

    // edge duties (R7)
    wr(3'd4, 8'd0); wr(3'd5, 8'd200);
    idle(220);
    @(negedge clk); check("R7 above modulus high", int'(pwmOut), 1);
    wr(3'd0, 8'h0D);
    @(negedge clk); check("R7 low-true inverts", int'(pwmOut), 0);
    wr(3'd0, 8'h05);
    wr(3'd4, 8'd0); wr(3'd5, 8'd0);
    idle(220);
    @(negedge clk); check("R7 zero compare low", int'(pwmOut), 0);

    // 50 percent duty (R7)
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h9C); wr(3'd3, 8'h40);
    wr(3'd4, 8'h4E); wr(3'd5, 8'h20);
    wr(3'd0, 8'h01);
    hi = 0;
    for (int i = 0; i < 40001; i++) begin
      @(negedge clk);
      if (pwmOut) hi++;
    end
    check("R7 half duty high count", hi, 20000);

    // free-running fallback (R4)
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd4, 8'h03); wr(3'd5, 8'hE8);
    wr(3'd0, 8'h01);
    wr(3'd4, 8'h07); wr(3'd5, 8'hD0);
    idle(40010);
    rd(3'd4, v); check("R4 no load at old modulus", v, 8'h03);
    idle(25600);
    rd(3'd4, hi); rd(3'd5, v);
    check("R4 loaded at 0xFFFF step", hi * 256 + v, 2000);
    rd(3'd6, v); check("R1 counter wrapped", int'(v < 8'h10), 1);

    summary();
  end
endmodule